// File: doc/BRIEF.md
# Resetting-Counter Branch Confidence Table

This block rates how far a branch prediction can be trusted. It holds a table of small counters, one per entry, and picks an entry by XOR-ing the branch address with the global branch history. A counter counts how many predictions in a row have been correct for the branches that map to its entry. A single wrong prediction clears the counter.

The lookup side is combinational. It takes an address, a history value and a threshold, and returns the stored counter together with a high-confidence flag. The update side is written at the clock edge. It takes an address, a history value, a valid strobe and a flag that says whether the prediction was correct. The threshold is an input, so the consumer can change it at run time. The predictor that produces the predictions, the history register and the logic that acts on the confidence flag all sit outside this block.

Top module: `brconf_table`

## Requirements
- R1: The entry index is the low IDX_W bits of (PC XOR history). The default IDX_W is 6, which gives 64 entries. Address and history bits above IDX_W have no effect on which entry is chosen.
- R2: An update with upd_valid=1 and upd_correct=1 adds one to the indexed counter.
- R3: A counter that already holds its maximum value (15 for the default 4-bit width) stays at that value after a correct update.
- R4: An update with upd_valid=1 and upd_correct=0 sets the indexed counter to zero.
- R5: lk_high is 1 only when lk_count is strictly greater than lk_thresh. Any threshold from 1 to 15 is accepted. A threshold of 15 therefore never yields high confidence.
- R6: After an asynchronous active-low reset every counter reads zero, so every lookup reports low confidence.
- R7: A lookup that selects the same entry as an update in the same cycle returns the value from before the update. The new value is visible from the next cycle on.
- R8: While upd_valid=0, no counter changes, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Branch address for the lookup |
| lk_hist | input | HIST_W | Global history for the lookup |
| lk_thresh | input | CNT_W | Confidence threshold |
| lk_count | output | CNT_W | Counter value of the selected entry |
| lk_high | output | 1 | 1 when lk_count is greater than lk_thresh |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | PC_W | Branch address for the update |
| upd_hist | input | HIST_W | Global history for the update |
| upd_correct | input | 1 | 1 when the prediction was correct, 0 when it was wrong |

## Verification
The lookup path is combinational, so a wrong counter shows up at lk_count on the first lookup that selects the damaged entry. It does not show up earlier. Likewise, a write to the wrong entry is only visible when both the intended entry and the entry that was actually hit are read back. For that reason the bench reads back aliased indices, and it runs random traffic limited to a few entries so that each entry is revisited many times. Saturation faults, clear faults and threshold-compare faults each surface in the cycle after the update that triggers them. The bench compares lk_count and lk_high every cycle against a behavioural model of the table.

// File: rtl/brconf_table.sv
module brconf_table #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [HIST_W-1:0] lk_hist,
  input  logic [CNT_W-1:0]  lk_thresh,
  output logic [CNT_W-1:0]  lk_count,
  output logic              lk_high,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_correct
);
  localparam int XW    = (PC_W > HIST_W) ? PC_W : HIST_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DEPTH-1:0][CNT_W-1:0] cnt_q;
  logic [XW-1:0]    lk_x, upd_x;
  logic [IDX_W-1:0] lk_idx, upd_idx;
  logic [CNT_W-1:0] upd_cur, upd_next;
  logic             unused_hi_bits;

  assign lk_x    = XW'(lk_pc) ^ XW'(lk_hist);
  assign upd_x   = XW'(upd_pc) ^ XW'(upd_hist);
  assign lk_idx  = lk_x[IDX_W-1:0];
  assign upd_idx = upd_x[IDX_W-1:0];
  assign unused_hi_bits = ^{lk_x, upd_x};

  assign lk_count = cnt_q[lk_idx];
  assign lk_high  = lk_count > lk_thresh;

  assign upd_cur  = cnt_q[upd_idx];
  assign upd_next = !upd_correct      ? '0 :
                    (upd_cur == CNT_MAX) ? upd_cur : upd_cur + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (upd_valid) cnt_q[upd_idx] <= upd_next;
  end
endmodule

module brconf_table_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 12,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                upd_valid,
  input logic                                upd_correct,
  input logic [PC_W-1:0]                     upd_pc,
  input logic [HIST_W-1:0]                   upd_hist,
  input logic [CNT_W-1:0]                    lk_count,
  input logic                                lk_high,
  input logic [(1<<IDX_W)-1:0][CNT_W-1:0]    cnt_q
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic [IDX_W-1:0] ui;
  assign ui = upd_pc[IDX_W-1:0] ^ upd_hist[IDX_W-1:0];

  assert_clear_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_correct) |=> cnt_q[$past(ui)] == '0);

  assert_step_or_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_correct && cnt_q[ui] != CMAX) |=> cnt_q[$past(ui)] == $past(cnt_q[ui]) + 1'b1);

  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_correct && cnt_q[ui] == CMAX) |=> cnt_q[$past(ui)] == CMAX);

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(cnt_q));

  assert_zero_is_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_count == '0) |-> !lk_high);
endmodule

bind brconf_table brconf_table_chk #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_correct(upd_correct),
  .upd_pc(upd_pc), .upd_hist(upd_hist), .lk_count(lk_count), .lk_high(lk_high),
  .cnt_q(cnt_q));

// File: tb/brconf_table_tb_top.sv
`timescale 1ns/1ps
module brconf_table_tb_top;
  localparam int PC_W = 32, HIST_W = 12, IDX_W = 6, CNT_W = 4;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic [HIST_W-1:0] lk_hist = '0, upd_hist = '0;
  logic [CNT_W-1:0] lk_thresh = 4'd1, lk_count;
  logic lk_high, upd_valid = 1'b0, upd_correct = 1'b0;

  int checks = 0, failures = 0;
  int model [DEPTH];
  bit done = 0;

  always #2.5 clk = ~clk;

  brconf_table #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hist(lk_hist), .lk_thresh(lk_thresh),
    .lk_count(lk_count), .lk_high(lk_high), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_hist(upd_hist), .upd_correct(upd_correct));

  function automatic int idx_of(int pc, int h);
    return (pc ^ h) & (DEPTH - 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic step(int lpc, int lh, int thr, bit uv, int upc, int uh, bit uc, string tag);
    int e, li, ui;
    @(negedge clk);
    lk_pc = PC_W'(lpc); lk_hist = HIST_W'(lh); lk_thresh = CNT_W'(thr);
    upd_valid = uv; upd_pc = PC_W'(upc); upd_hist = HIST_W'(uh); upd_correct = uc;
    #1;
    li = idx_of(lpc, lh);
    e = model[li];
    checks++;
    if (int'(lk_count) != e) begin
      failures++;
      $display("FAIL %s count idx=%0d actual=%0d expected=%0d", tag, li, lk_count, e);
    end
    checks++;
    if (lk_high != (e > thr)) begin
      failures++;
      $display("FAIL %s high thr=%0d actual=%0b expected=%0b", tag, thr, lk_high, e > thr);
    end
    @(posedge clk);
    if (uv) begin
      ui = idx_of(upc, uh);
      if (!uc) model[ui] = 0;
      else if (model[ui] < MAXC) model[ui]++;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R6: every entry zero, low confidence
    for (int i = 0; i < DEPTH; i++) step(i, 0, 1, 0, 0, 0, 0, "R6");
    // R1: update pc=5 hist=3 -> entry 6; read through aliases
    step(0, 0, 1, 1, 5, 3, 1, "R1");
    step(6, 0, 1, 0, 0, 0, 0, "R1");
    step('h46, 0, 1, 0, 0, 0, 0, "R1");
    step(0, 'h806, 1, 0, 0, 0, 0, "R1");
    step(7, 1, 1, 0, 0, 0, 0, "R1");
    step(5, 0, 1, 0, 0, 0, 0, "R1");
    // R2 R3 R7: drive entry 9 past saturation while looking at it
    for (int k = 0; k < 20; k++) step(9, 0, 14, 1, 8, 1, 1, "R2 R3 R7");
    step(9, 0, 15, 0, 0, 0, 0, "R5");
    step(9, 0, 14, 0, 0, 0, 0, "R5");
    // R5: entry 12 at 3
    for (int k = 0; k < 3; k++) step(0, 0, 1, 1, 12, 0, 1, "R2");
    step(12, 0, 2, 0, 0, 0, 0, "R5");
    step(12, 0, 3, 0, 0, 0, 0, "R5");
    step(12, 0, 1, 0, 0, 0, 0, "R5");
    // R4 with R7: clear entry 9 while reading it
    step(9, 0, 1, 1, 9, 0, 0, "R4 R7");
    step(9, 0, 1, 0, 0, 0, 0, "R4");
    // R8: invalid update does nothing
    step(12, 0, 1, 0, 12, 0, 0, "R8");
    step(12, 0, 1, 0, 12, 0, 1, "R8");
    step(12, 0, 2, 0, 0, 0, 0, "R8");
    // mixed traffic on a few entries
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom;
      step($urandom & 'h3c3, $urandom & 'h3, 1 + ($urandom % 15), r[0],
           $urandom & 'h1c3, $urandom & 'h3, (r[3:1] != 0), "R2 R4 R5 R7 R8");
    end
    finish_run();
  end
endmodule